// File: doc/BRIEF.md
# Bit-Serial Clock and Battery-RAM Slave

This block is a timekeeping and non-volatile storage slave reached through three bits of a system control register: an enable, a serial clock and a data bit. Firmware frames a transaction by raising the enable. It then toggles the serial clock sixteen times. The first eight falling edges carry a command byte, most significant bit first. The next eight carry a value byte, and during those same eight edges the block returns a response byte on its own registered data output.

The command chooses what the transaction does. It can read or write one of 32 battery-backed RAM bytes, read a status byte or a control byte, or read BCD time fields. The seconds, minutes and hours come from a counter that advances on a one-second tick. Day, month and year are fixed by parameters. One write command clears the fault flag pair in the status byte and emits a one-cycle pulse that clears an interrupt-status bit elsewhere in the chip.

The serial engine is a four-state machine: IDLE (enable low), CMD (collecting command bits), DATA (collecting value bits while driving response bits) and HOLD (transaction complete, further edges ignored). The transitions are as follows:
- Any state goes to IDLE whenever enable is low, which is the abort.
- IDLE goes to CMD once enable is high. A falling edge seen in that cycle already counts as command bit 0.
- CMD goes to DATA after the eighth command edge.
- DATA goes to HOLD after the eighth value edge, and that edge also commits the transaction.
- HOLD stays in HOLD until enable falls.

Top module: `rtc_serial_slave`

## Requirements
- R1: After reset `sdata_o` and `irq_clr_o` are 0, the status byte is 0x90 and the RAM holds its default image, including byte 0x00 = 0x94, byte 0x0A = 0xFB and byte 0x1F = 0x7E.
- R2: A bit is taken only on a falling edge of `sclk_i`, meaning the previous cycle's `sclk_i` was 1 and the current one is 0, and only while `ce_i` is 1. Edges while `ce_i` is 0 have no effect.
- R3: On each of the eight value edges the block drives the next response bit, MSB first, onto `sdata_o`, registered on the clock after the edge. `sdata_o` changes at no other time while `ce_i` is high. Commands that read nothing return 0x00.
- R4: Commands 0x00 to 0x1F return the RAM byte at that index.
- R5: Command 0x30 returns the status byte. Command 0x31 returns the control byte, which is parameter CTRL_INIT (default 0x00).
- R6: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return, as (tens<<4)|units, the seconds, minutes, hours, day, month and two-digit year. The last three are parameters with defaults 1, 1 and 24. Every other command from 0x20 to 0x2F returns 0x00.
- R7: Each cycle with `sec_tick_i` high advances seconds. Seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 to 0 and carry into hours, and hours wrap from 23 to 0.
- R8: After the sixteenth bit, commands 0x80 to 0x9F store the value byte into RAM index command minus 0x80.
- R9: After the sixteenth bit, command 0xB1 with value bit 2 set clears status bits 3 and 4 and raises `irq_clr_o` for exactly one cycle. With value bit 2 clear, the command changes nothing.
- R10: Dropping `ce_i` mid-transaction discards the partial command and value, so no write takes place, and the next transaction starts again at command bit 0.
- R11: Falling edges after the sixteenth bit are ignored until `ce_i` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_i | input | 1 | Transaction enable; low aborts and idles |
| sclk_i | input | 1 | Serial clock, sampled by `clk` |
| sdata_i | input | 1 | Serial data from the host |
| sec_tick_i | input | 1 | One-cycle pulse per elapsed second |
| sdata_o | output | 1 | Registered serial response bit |
| irq_clr_o | output | 1 | One-cycle pulse clearing the external interrupt-status bit |

## Verification
The assertions assume that `sclk_i`, `ce_i` and `sdata_i` come from a register in the `clk` domain. They also assume that a serial clock phase lasts long enough for each falling edge to be seen as one 1-to-0 step between consecutive cycles. The bench satisfies both by driving these inputs on the inactive clock edge and holding every half period of `sclk_i` for two cycles. It also keeps `sdata_i` steady across each falling edge and raises `ce_i` two cycles before the first edge of every transaction.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BYTE_W    = 8;
    localparam int RAM_DEPTH = 32;
    localparam int RAM_AW    = $clog2(RAM_DEPTH);
    localparam int CNT_W     = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] OP_WR_BASE   = 8'h80;
    localparam logic [BYTE_W-1:0] OP_TIME_BASE = 8'h20;
    localparam logic [BYTE_W-1:0] OP_STATUS    = 8'h30;
    localparam logic [BYTE_W-1:0] OP_CONTROL   = 8'h31;
    localparam logic [BYTE_W-1:0] OP_FLAG_CLR  = 8'hB1;

    localparam logic [BYTE_W-1:0] STATUS_RESET = 8'h90;
    localparam logic [BYTE_W-1:0] STATUS_FLAGS = 8'h18;
    localparam int                CLR_REQ_BIT  = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2,
        ST_HOLD = 2'd3
    } ser_state_e;

    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] units;
        tens  = v / 7'd10;
        units = v - 7'(tens * 7'd10);
        return {tens[3:0], units[3:0]};
    endfunction

    function automatic logic [BYTE_W-1:0] ram_default(input int idx);
        case (idx)
            0:       return 8'h94;
            1:       return 8'h0F;
            2:       return 8'h40;
            3:       return 8'h03;
            10:      return 8'hFB;
            11:      return 8'h6D;
            14:      return 8'h4B;
            16:      return 8'h41;
            18:      return 8'h20;
            30:      return 8'h84;
            31:      return 8'h7E;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    output logic [5:0] sec_o,
    output logic [5:0] min_o,
    output logic [4:0] hr_o
);
    localparam logic [5:0] SEC_MAX = 6'd59;
    localparam logic [5:0] MIN_MAX = 6'd59;
    localparam logic [4:0] HR_MAX  = 5'd23;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_o <= '0;
            min_o <= '0;
            hr_o  <= '0;
        end else if (tick_i) begin
            if (sec_o == SEC_MAX) begin
                sec_o <= '0;
                if (min_o == MIN_MAX) begin
                    min_o <= '0;
                    hr_o  <= (hr_o == HR_MAX) ? 5'd0 : hr_o + 5'd1;
                end else begin
                    min_o <= min_o + 6'd1;
                end
            end else begin
                sec_o <= sec_o + 6'd1;
            end
        end
    end
endmodule

// File: rtl/rtc_shift_fsm.sv
module rtc_shift_fsm
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_i,
    input  logic              sclk_i,
    input  logic              din_i,
    input  logic [BYTE_W-1:0] resp_i,
    output logic [BYTE_W-1:0] cmd_o,
    output logic [BYTE_W-1:0] val_o,
    output logic              commit_o,
    output logic              dout_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    ser_state_e        state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [BYTE_W-1:0] cmd_n, val_n;
    logic              sclk_q;
    logic              fall;

    assign fall = ce_i && sclk_q && !sclk_i;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        cmd_n   = cmd_o;
        val_n   = val_o;
        if (!ce_i) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
            cmd_n   = '0;
            val_n   = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_n = ST_CMD;
                    cnt_n   = '0;
                    if (fall) begin
                        cmd_n = {cmd_o[BYTE_W-2:0], din_i};
                        cnt_n = CNT_W'(1);
                    end
                end
                ST_CMD: begin
                    if (fall) begin
                        cmd_n = {cmd_o[BYTE_W-2:0], din_i};
                        cnt_n = cnt + CNT_W'(1);
                        if (cnt == LAST) begin
                            state_n = ST_DATA;
                            cnt_n   = '0;
                        end
                    end
                end
                ST_DATA: begin
                    if (fall) begin
                        val_n = {val_o[BYTE_W-2:0], din_i};
                        cnt_n = cnt + CNT_W'(1);
                        if (cnt == LAST) begin
                            state_n = ST_HOLD;
                            cnt_n   = '0;
                        end
                    end
                end
                ST_HOLD: begin
                    state_n = ST_HOLD;
                end
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            cmd_o  <= '0;
            val_o  <= '0;
            sclk_q <= 1'b0;
        end else begin
            state  <= state_n;
            cnt    <= cnt_n;
            cmd_o  <= cmd_n;
            val_o  <= val_n;
            sclk_q <= sclk_i;
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_o   <= 1'b0;
            commit_o <= 1'b0;
        end else begin
            commit_o <= (state == ST_DATA) && fall && (cnt == LAST);
            if (!ce_i) begin
                dout_o <= 1'b0;
            end else if ((state == ST_DATA) && fall) begin
                dout_o <= resp_i[LAST - cnt];
            end
        end
    end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter logic [6:0]        DAY_INIT  = 7'd1,
    parameter logic [6:0]        MON_INIT  = 7'd1,
    parameter logic [6:0]        YEAR_INIT = 7'd24,
    parameter logic [BYTE_W-1:0] CTRL_INIT = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] cmd_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              commit_i,
    input  logic [5:0]        sec_i,
    input  logic [5:0]        min_i,
    input  logic [4:0]        hr_i,
    output logic [BYTE_W-1:0] resp_o,
    output logic              irq_clr_o
);
    logic [BYTE_W-1:0] ram [RAM_DEPTH];
    logic [BYTE_W-1:0] status_q;
    logic [RAM_AW-1:0] idx;
    logic              is_rd, is_wr, is_time, do_clr;

    assign idx     = cmd_i[RAM_AW-1:0];
    assign is_rd   = cmd_i < BYTE_W'(RAM_DEPTH);
    assign is_wr   = (cmd_i >= OP_WR_BASE) && (cmd_i < OP_WR_BASE + BYTE_W'(RAM_DEPTH));
    assign is_time = cmd_i[BYTE_W-1:4] == OP_TIME_BASE[BYTE_W-1:4];
    assign do_clr  = commit_i && (cmd_i == OP_FLAG_CLR) && wdata_i[CLR_REQ_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= ram_default(i);
        end else if (commit_i && is_wr) begin
            ram[idx] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q  <= STATUS_RESET;
            irq_clr_o <= 1'b0;
        end else begin
            irq_clr_o <= do_clr;
            if (do_clr) status_q <= status_q & ~STATUS_FLAGS;
        end
    end

    always_comb begin
        resp_o = '0;
        if (is_rd) begin
            resp_o = ram[idx];
        end else if (cmd_i == OP_STATUS) begin
            resp_o = status_q;
        end else if (cmd_i == OP_CONTROL) begin
            resp_o = CTRL_INIT;
        end else if (is_time) begin
            case (cmd_i[3:0])
                4'h0:    resp_o = to_bcd({1'b0, sec_i});
                4'h1:    resp_o = to_bcd({1'b0, min_i});
                4'h2:    resp_o = to_bcd({2'b00, hr_i});
                4'h4:    resp_o = to_bcd(DAY_INIT);
                4'h5:    resp_o = to_bcd(MON_INIT);
                4'h6:    resp_o = to_bcd(YEAR_INIT);
                default: resp_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
    import rtc_pkg::*;
#(
    parameter logic [6:0]        DAY_INIT  = 7'd1,
    parameter logic [6:0]        MON_INIT  = 7'd1,
    parameter logic [6:0]        YEAR_INIT = 7'd24,
    parameter logic [BYTE_W-1:0] CTRL_INIT = 8'h00
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_i,
    input  logic sclk_i,
    input  logic sdata_i,
    input  logic sec_tick_i,
    output logic sdata_o,
    output logic irq_clr_o
);
    logic [BYTE_W-1:0] cmd, val, resp;
    logic              commit;
    logic [5:0]        sec, mins;
    logic [4:0]        hrs;

    rtc_timekeeper u_time (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (sec_tick_i),
        .sec_o  (sec),
        .min_o  (mins),
        .hr_o   (hrs)
    );

    rtc_shift_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_i     (ce_i),
        .sclk_i   (sclk_i),
        .din_i    (sdata_i),
        .resp_i   (resp),
        .cmd_o    (cmd),
        .val_o    (val),
        .commit_o (commit),
        .dout_o   (sdata_o)
    );

    rtc_regfile #(
        .DAY_INIT  (DAY_INIT),
        .MON_INIT  (MON_INIT),
        .YEAR_INIT (YEAR_INIT),
        .CTRL_INIT (CTRL_INIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd),
        .wdata_i   (val),
        .commit_i  (commit),
        .sec_i     (sec),
        .min_i     (mins),
        .hr_i      (hrs),
        .resp_o    (resp),
        .irq_clr_o (irq_clr_o)
    );
endmodule

// File: rtl/rtc_serial_slave_chk.sv
module rtc_serial_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_i,
    input logic sclk_i,
    input logic sdata_o,
    input logic irq_clr_o
);
    logic sclk_d;

    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_i;
    end

    // R9: the clear pulse lasts one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr_o |=> !irq_clr_o);

    // R9: the clear pulse follows a falling edge seen two cycles earlier with enable high
    a_r9_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr_o |-> $past(ce_i && sclk_d && !sclk_i, 2));

    // R10: a low enable forces the response bit low
    a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_i |=> !sdata_o);

    // R3: while enabled, the response bit moves only on a falling edge
    a_r3_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_i && !(sclk_d && !sclk_i)) |=> $stable(sdata_o));
endmodule

bind rtc_serial_slave rtc_serial_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_i      (ce_i),
    .sclk_i    (sclk_i),
    .sdata_o   (sdata_o),
    .irq_clr_o (irq_clr_o)
);

// File: tb/rtc_serial_slave_tb_top.sv
`timescale 1ns/1ps
module rtc_serial_slave_tb_top;

    logic clk = 1'b0;
    logic rst_n, ce_i, sclk_i, sdata_i, sec_tick_i;
    logic sdata_o, irq_clr_o;

    always #2 clk = ~clk;

    rtc_serial_slave dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_i       (ce_i),
        .sclk_i     (sclk_i),
        .sdata_i    (sdata_i),
        .sec_tick_i (sec_tick_i),
        .sdata_o    (sdata_o),
        .irq_clr_o  (irq_clr_o)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] got;
    event       got_ev;
    int         total = 0;
    int         bad   = 0;
    int         irq_cnt = 0;
    bit         finished = 0;

    always @(negedge clk) if (rst_n && irq_clr_o) irq_cnt++;

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: compares each returned byte against the scoreboard queue
    initial begin
        forever begin
            @(got_ev);
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard empty actual=%02h expected=none", got);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(got, it.exp, it.tag);
            end
        end
    end

    task automatic send_bits(input logic [15:0] word, input int n, output logic [7:0] resp);
        resp = '0;
        for (int i = 0; i < n; i++) begin
            sdata_i = word[15-i];
            sclk_i  = 1'b1;
            repeat (2) @(negedge clk);
            sclk_i  = 1'b0;
            repeat (2) @(negedge clk);
            if (i >= 8) resp = {resp[6:0], sdata_o};
        end
    endtask

    task automatic begin_tx();
        ce_i = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic end_tx();
        ce_i    = 1'b0;
        sdata_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // driver: pushes the expectation, runs a full 16-bit transaction
    task automatic txn(input logic [7:0] c, input logic [7:0] v, input logic [7:0] exp, input string tag);
        logic [7:0] r;
        item_t it;
        it.exp = exp;
        it.tag = tag;
        exp_q.push_back(it);
        begin_tx();
        send_bits({c, v}, 16, r);
        end_tx();
        got = r;
        -> got_ev;
        #0;
    endtask

    initial begin
        #(4ns * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] dummy;
        rst_n = 1'b0; ce_i = 1'b0; sclk_i = 1'b0; sdata_i = 1'b0; sec_tick_i = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({7'd0, sdata_o},   8'h00, "R1 sdata_o at reset");
        check({7'd0, irq_clr_o}, 8'h00, "R1 irq_clr_o at reset");

        // R2: edges with enable low are ignored
        for (int k = 0; k < 4; k++) begin
            sdata_i = 1'b1; sclk_i = 1'b1; repeat (2) @(negedge clk);
            sclk_i = 1'b0; repeat (2) @(negedge clk);
        end
        sdata_i = 1'b0;
        check({7'd0, sdata_o}, 8'h00, "R2 no response with enable low");

        txn(8'h00, 8'h00, 8'h94, "R1 R4 ram[00] default");
        txn(8'h1F, 8'hFF, 8'h7E, "R1 R4 ram[1F] default");
        txn(8'h0A, 8'h00, 8'hFB, "R4 ram[0A]");
        txn(8'h30, 8'h00, 8'h90, "R1 R5 status reset");
        txn(8'h31, 8'h00, 8'h00, "R5 control");
        txn(8'h20, 8'h00, 8'h00, "R6 seconds");
        txn(8'h24, 8'h00, 8'h01, "R6 day");
        txn(8'h25, 8'h00, 8'h01, "R6 month");
        txn(8'h26, 8'h00, 8'h24, "R6 year");
        txn(8'h23, 8'h00, 8'h00, "R6 unused time slot");
        txn(8'h2F, 8'h00, 8'h00, "R6 unused time slot 2F");

        txn(8'h9F, 8'hC3, 8'h00, "R3 write returns zero");
        txn(8'h1F, 8'h00, 8'hC3, "R8 ram[1F] written");
        txn(8'h85, 8'hA5, 8'h00, "R3 write returns zero 85");
        txn(8'h05, 8'h00, 8'hA5, "R8 ram[05] written");

        // R10: abort after twelve bits
        begin_tx();
        send_bits({8'h83, 8'h77}, 12, dummy);
        end_tx();
        txn(8'h03, 8'h00, 8'h03, "R10 aborted write left ram[03]");

        // R11: extra edges after a complete write are ignored
        begin_tx();
        send_bits({8'h82, 8'h5A}, 16, dummy);
        send_bits(16'hFF00, 16, dummy);
        end_tx();
        txn(8'h02, 8'h00, 8'h5A, "R11 ram[02] holds first write");
        txn(8'h82, 8'h00, 8'h00, "R8 restore setup");
        txn(8'h02, 8'h00, 8'h00, "R8 ram[02] rewritten");

        // R9: flag clear only with value bit 2
        txn(8'hB1, 8'h00, 8'h00, "R9 clear without bit2");
        check(8'(irq_cnt), 8'h00, "R9 no pulse without bit2");
        txn(8'h30, 8'h00, 8'h90, "R9 status unchanged");
        txn(8'hB1, 8'h04, 8'h00, "R9 clear with bit2");
        check(8'(irq_cnt), 8'h01, "R9 one pulse");
        txn(8'h30, 8'h00, 8'h80, "R9 status flags cleared");

        // R7: 3661 ticks -> 01:01:01
        sec_tick_i = 1'b1;
        repeat (3661) @(negedge clk);
        sec_tick_i = 1'b0;
        txn(8'h20, 8'h00, 8'h01, "R7 seconds after 3661");
        txn(8'h21, 8'h00, 8'h01, "R7 minutes after 3661");
        txn(8'h22, 8'h00, 8'h01, "R7 hours after 3661");
        sec_tick_i = 1'b1;
        repeat (82739) @(negedge clk);
        sec_tick_i = 1'b0;
        txn(8'h22, 8'h00, 8'h00, "R7 hours wrap");
        txn(8'h21, 8'h00, 8'h00, "R7 minutes wrap");
        txn(8'h20, 8'h00, 8'h00, "R7 seconds wrap");

        #1;
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule